// File: doc/BRIEF.md
# Four-Byte Serial Programming Frame Target

This block is the target end of a three-wire synchronous programming link (serial clock, host-to-target data, target-to-host data). The link is live only while the target reset input is held low. The host sends every instruction as a fixed frame of four bytes, most significant bit first. The block decodes each frame into an opcode, two address bytes and a data byte, and hands them to downstream memory controllers with a one-cycle strobe. During the fourth byte of every frame it returns a byte supplied by the downstream logic.

Before any command is accepted, the host must send a programming-enable frame. Its opcode is 0xAC and its second byte must be 0x53. While the third byte of that frame is clocked in, the block shifts the received second byte back out. This lets the host confirm that the bit framing is aligned. If the echo is wrong, the host pulses reset high to clear the framing and tries again.

All link inputs pass through two-flop synchronizers into the system clock domain. Serial clock edges are detected from the synchronized samples, so the serial clock must be several times slower than the system clock.

Top module: `isp_frame_target`

## Requirements
- R1: Data on `mosi_i` is captured at each rising edge of `sck_i`, most significant bit first. Byte 1 of a frame appears on `opcode_o`, byte 2 on `addr_hi_o`, byte 3 on `addr_lo_o` and byte 4 on `data_o`.
- R2: A frame is exactly 32 serial clocks long. After the 32nd rising edge, `instr_valid_o` pulses for exactly one system clock. It pulses only if programming mode was already enabled and the opcode is not 0xAC.
- R3: While `prog_en_o` is low, frames other than a valid enable frame produce no `instr_valid_o` pulse.
- R4: In a frame whose opcode is 0xAC, the received byte 2 is shifted out on `miso_o` during byte 3, MSB first. `miso_o` changes only after a falling edge of `sck_i`. If byte 2 equals 0x53, `prog_en_o` rises at the end of the frame.
- R5: An enable frame with a wrong byte 2 leaves `prog_en_o` low. All four of its bytes are still consumed, so the next frame starts aligned.
- R6: While `tgt_rst_i` is high, the bit count, the partial frame and `prog_en_o` are cleared and `miso_o` is held low. After reset is released, the next serial clock starts a fresh frame.
- R7: During byte 4 of every frame, `miso_o` carries `rd_data_i`, MSB first. `rd_data_i` is sampled at the falling edge that ends byte 3.
- R8: During bytes 1 and 2, and during byte 3 of frames whose opcode is not 0xAC, `miso_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| tgt_rst_i | input | 1 | Target reset; the link is active while this is low |
| sck_i | input | 1 | Serial clock from the host |
| mosi_i | input | 1 | Serial data from the host |
| miso_o | output | 1 | Serial data to the host |
| rd_data_i | input | 8 | Byte returned during byte 4 of each frame |
| opcode_o | output | 8 | Decoded byte 1 |
| addr_hi_o | output | 8 | Decoded byte 2 |
| addr_lo_o | output | 8 | Decoded byte 3 |
| data_o | output | 8 | Decoded byte 4 |
| instr_valid_o | output | 1 | One-cycle strobe for an accepted instruction |
| prog_en_o | output | 1 | Programming mode enabled |

## Verification
The hardest case to reach from the ports is a link whose framing has slipped. In that case the echo no longer matches, and only a reset pulse restores alignment. The stimulus sends a partial frame of 13 bits and then pulses the target reset. It then shows that a fresh enable frame echoes correctly and that a following command decodes with the right fields. A rejected enable frame, with 0x52 in byte 2, is followed directly by a good one. This shows that the rejected frame still consumed all four bytes.

// File: rtl/isp_frame_pkg.sv
package isp_frame_pkg;
    localparam int BYTE_W      = 8;
    localparam int FRAME_BYTES = 4;
    localparam int FRAME_BITS  = BYTE_W * FRAME_BYTES;
    localparam int CNT_W       = $clog2(FRAME_BITS);
    localparam int IDX_W       = $clog2(FRAME_BYTES);
    localparam int POS_W       = $clog2(BYTE_W);

    typedef struct packed {
        logic [CNT_W-1:0]  bit_cnt;
        logic [BYTE_W-1:0] rx;
        logic [BYTE_W-1:0] op;
        logic [BYTE_W-1:0] ahi;
        logic [BYTE_W-1:0] alo;
        logic [BYTE_W-1:0] dat;
        logic [BYTE_W-1:0] tx;
        logic              miso;
        logic              en;
        logic              vld;
    } isp_state_t;
endpackage

// File: rtl/isp_sync.sv
module isp_sync #(
    parameter int         W      = 1,
    parameter int         STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
        end else begin
            stg_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
        end
    end

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/isp_edge.sv
module isp_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic rise_o,
    output logic fall_o
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl_i;
    end

    assign rise_o = lvl_i & ~prev_q;
    assign fall_o = ~lvl_i & prev_q;
endmodule

// File: rtl/isp_frame_target.sv
module isp_frame_target
    import isp_frame_pkg::*;
#(
    parameter logic [7:0] ENABLE_OP   = 8'hAC,
    parameter logic [7:0] SYNC_CODE   = 8'h53,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tgt_rst_i,
    input  logic       sck_i,
    input  logic       mosi_i,
    output logic       miso_o,
    input  logic [7:0] rd_data_i,
    output logic [7:0] opcode_o,
    output logic [7:0] addr_hi_o,
    output logic [7:0] addr_lo_o,
    output logic [7:0] data_o,
    output logic       instr_valid_o,
    output logic       prog_en_o
);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(BYTE_W - 1);

    logic       sck_s, mosi_s, rst_s;
    logic       sck_rise, sck_fall;
    isp_state_t s_d, s_q;

    isp_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sck (
        .clk(clk), .rst_n(rst_n), .d_i(sck_i), .q_o(sck_s));
    isp_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_mosi (
        .clk(clk), .rst_n(rst_n), .d_i(mosi_i), .q_o(mosi_s));
    isp_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_rst (
        .clk(clk), .rst_n(rst_n), .d_i(tgt_rst_i), .q_o(rst_s));

    isp_edge u_edge (
        .clk(clk), .rst_n(rst_n), .lvl_i(sck_s), .rise_o(sck_rise), .fall_o(sck_fall));

    always_comb begin
        logic [BYTE_W-1:0] rx_n;
        logic [BYTE_W-1:0] ld;
        logic [IDX_W-1:0]  idx;
        logic [POS_W-1:0]  pos;
        s_d     = s_q;
        s_d.vld = 1'b0;
        rx_n    = {s_q.rx[BYTE_W-2:0], mosi_s};
        ld      = '0;
        idx     = s_q.bit_cnt[CNT_W-1:POS_W];
        pos     = s_q.bit_cnt[POS_W-1:0];
        if (rst_s) begin
            s_d = '0;
        end else if (sck_rise) begin
            s_d.rx      = rx_n;
            s_d.bit_cnt = s_q.bit_cnt + CNT_W'(1);
            if (pos == LAST_POS) begin
                case (idx)
                    IDX_W'(0): s_d.op  = rx_n;
                    IDX_W'(1): s_d.ahi = rx_n;
                    IDX_W'(2): s_d.alo = rx_n;
                    default: begin
                        s_d.dat = rx_n;
                        if (s_q.op == ENABLE_OP) begin
                            if (s_q.ahi == SYNC_CODE) s_d.en = 1'b1;
                        end else if (s_q.en) begin
                            s_d.vld = 1'b1;
                        end
                    end
                endcase
            end
        end else if (sck_fall) begin
            if (pos == '0) begin
                case (idx)
                    IDX_W'(2): ld = (s_q.op == ENABLE_OP) ? s_q.ahi : '0;
                    IDX_W'(3): ld = rd_data_i;
                    default:   ld = '0;
                endcase
                s_d.miso = ld[BYTE_W-1];
                s_d.tx   = {ld[BYTE_W-2:0], 1'b0};
            end else begin
                s_d.miso = s_q.tx[BYTE_W-1];
                s_d.tx   = {s_q.tx[BYTE_W-2:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign miso_o        = s_q.miso;
    assign opcode_o      = s_q.op;
    assign addr_hi_o     = s_q.ahi;
    assign addr_lo_o     = s_q.alo;
    assign data_o        = s_q.dat;
    assign instr_valid_o = s_q.vld;
    assign prog_en_o     = s_q.en;
endmodule

// File: rtl/isp_frame_chk.sv
module isp_frame_chk #(
    parameter logic [7:0] ENABLE_OP = 8'hAC
) (
    input logic       clk,
    input logic       rst_n,
    input logic       rst_s,
    input logic       sck_fall,
    input logic       miso_o,
    input logic       instr_valid_o,
    input logic       prog_en_o,
    input logic [7:0] opcode_o
);
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid_o |=> !instr_valid_o);

    a_r2_not_enable_op: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid_o |-> (opcode_o != ENABLE_OP));

    a_r3_strobe_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid_o |-> prog_en_o);

    a_r4_miso_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(miso_o) |-> ($past(sck_fall) || $past(rst_s)));

    a_r6_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        rst_s |=> (!prog_en_o && !miso_o && !instr_valid_o));

    a_r5_en_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_en_o && !rst_s) |=> prog_en_o);
endmodule

bind isp_frame_target isp_frame_chk #(.ENABLE_OP(ENABLE_OP)) u_chk (
    .clk(clk), .rst_n(rst_n), .rst_s(rst_s), .sck_fall(sck_fall),
    .miso_o(miso_o), .instr_valid_o(instr_valid_o), .prog_en_o(prog_en_o),
    .opcode_o(opcode_o));

// File: tb/isp_frame_target_tb.sv
module isp_frame_target_tb;
    localparam int HALF = 8;

    logic clk = 0, rst_n = 0, tgt_rst = 1, sck = 0, mosi = 0;
    logic miso, vld, pen;
    logic [7:0] rd_data, op, ah, al, dt;
    int total = 0, bad = 0;
    logic [31:0] exp_q [$];

    always #5 clk = ~clk;

    assign rd_data = al ^ 8'h5A;

    isp_frame_target u_dut (
        .clk(clk), .rst_n(rst_n), .tgt_rst_i(tgt_rst), .sck_i(sck), .mosi_i(mosi),
        .miso_o(miso), .rd_data_i(rd_data), .opcode_o(op), .addr_hi_o(ah),
        .addr_lo_o(al), .data_o(dt), .instr_valid_o(vld), .prog_en_o(pen));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: every strobe must match the head of the scoreboard
    always @(negedge clk) begin
        if (rst_n && vld) begin
            if (exp_q.size() == 0) begin
                check("R3 unexpected strobe", {op, ah, al, dt}, 32'h0);
            end else begin
                check("R1/R2 decoded fields", {op, ah, al, dt}, exp_q.pop_front());
            end
        end
    end

    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic xfer_bits(input logic [31:0] w, input int n, output logic [31:0] r);
        r = '0;
        for (int i = n - 1; i >= 0; i--) begin
            mosi = w[i];
            wait_clk(HALF);
            r[i] = miso;
            sck = 1;
            wait_clk(HALF);
            sck = 0;
        end
    endtask

    task automatic frame(input logic [31:0] w, input bit strobe, output logic [31:0] r);
        if (strobe) exp_q.push_back(w);
        xfer_bits(w, 32, r);
        wait_clk(2 * HALF);
    endtask

    logic [31:0] r;

    initial begin
        #2_000_000;
        check("watchdog", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait_clk(3);
        rst_n = 1;
        wait_clk(5);
        check("R6 reset prog_en", pen, 0);
        check("R6 reset miso", miso, 0);
        tgt_rst = 0;
        wait_clk(5);
        check("R2 no strobe at reset", vld, 0);

        // R3: command before enable is ignored
        frame(32'h4000_05A7, 0, r);
        check("R3 prog_en stays low", pen, 0);
        check("R8 miso low in bytes 1-3", r[31:8], 0);

        // R5: bad sync byte, echo shows received value, stays disabled
        frame(32'hAC52_0000, 0, r);
        check("R4 echo of wrong byte", r[15:8], 8'h52);
        check("R5 prog_en low after bad sync", pen, 0);

        // R4: good enable, aligned after rejected frame
        frame(32'hAC53_0000, 0, r);
        check("R4 echo 0x53", r[15:8], 8'h53);
        check("R8 miso low bytes 1-2", r[31:16], 0);
        check("R4 prog_en set", pen, 1);

        // R1/R2 commands with strobes
        frame(32'h4000_05A7, 1, r);
        frame(32'hC1FF_8001, 1, r);
        frame(32'h4C12_3400, 1, r);
        check("R8 no echo in non-enable frame", r[15:8], 0);

        // R7: read data returned in byte 4
        frame(32'h2000_1200, 1, r);
        check("R7 read byte", r[7:0], 8'h12 ^ 8'h5A);
        frame(32'h2003_C300, 1, r);
        check("R7 read byte 2", r[7:0], 8'hC3 ^ 8'h5A);

        // R2: enable frame while enabled gives no strobe
        frame(32'hAC53_0000, 0, r);
        check("R2 still enabled", pen, 1);

        // R6: slip framing with partial frame, recover with reset pulse
        xfer_bits(32'h0000_1A5B, 13, r);
        tgt_rst = 1;
        wait_clk(10);
        check("R6 prog_en cleared", pen, 0);
        check("R6 miso cleared", miso, 0);
        tgt_rst = 0;
        wait_clk(5);
        frame(32'h40AA_5511, 0, r);
        check("R6 R3 ignored after reset", pen, 0);
        frame(32'hAC53_0000, 0, r);
        check("R6 echo realigned", r[15:8], 8'h53);
        check("R6 re-enabled", pen, 1);
        frame(32'h48A5_5AC3, 1, r);

        wait_clk(20);
        check("R2 all strobes seen", exp_q.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule